// File: doc/BRIEF.md
# Half-Duplex Back-Pressure Jam Controller

This block sits beside a half-duplex Ethernet MAC and decides when the MAC should throttle a remote sender. When the local receive buffer is full enough, the MAC forces a collision on each new incoming frame. The remote station sees the collision and backs off. The block does not generate the jam pattern itself. It emits a one-cycle jam request that the transmit path turns into a jam on the wire.

A jam is only ever requested at the start of a newly arriving frame, so the collision it causes is never a late one. Jamming every frame forever can make a hub partition the port. To prevent this, the block counts consecutive collisions on both the transmit and receive sides. When that count reaches a programmable limit, the next received frame is let through without a jam, and the leak is signalled. Any frame that ends without a collision restarts the count.

Top module: `bp_jam_ctrl`

## Requirements
- R1: On a cycle with `rx_sof` high, if `fill_level >= fill_thresh` (equality included) and no leak applies, `jam_req` is high in the following cycle. If the fill is below the threshold, no jam is requested.
- R2: `jam_req` is never high except in the cycle right after an `rx_sof` strobe, and it lasts exactly one cycle.
- R3: Each end event with its collision flag set (`tx_end` with `tx_coll`, or `rx_end` with `rx_coll`) adds one to the consecutive-collision count. Two such events in the same cycle add two.
- R4: An end event whose collision flag is low clears the count to zero. If that cycle also carries collided events, the clear wins.
- R5: This rule applies when `jam_limit` is non-zero, the count is at or above it, `rx_sof` is high and the fill is at or above the threshold. In that case `jam_req` stays low, `leak_pulse` is high for one cycle in the following cycle, and the count is cleared, so the next frame is jammed again.
- R6: A `jam_limit` of zero disables leakage: every over-threshold frame is jammed, whatever the count.
- R7: The count saturates at 255 and never wraps.
- R8: An `rx_sof` that arrives while the buffer is below threshold neither jams nor leaks, and it leaves the count unchanged.
- R9: Synchronous active-high `rst` clears the count and drives `jam_req` and `leak_pulse` low.
- R10: When a leak occurs in the same cycle as collided end events, the count is zero afterwards. The collided events of that cycle are dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fill_level | input | 8 | Current receive-buffer occupancy |
| fill_thresh | input | 8 | Occupancy at or above which back-pressure applies |
| rx_sof | input | 1 | One-cycle strobe at the start of a newly arriving frame |
| tx_end | input | 1 | One-cycle strobe when a transmitted frame ends |
| tx_coll | input | 1 | Qualifies `tx_end`: the frame saw a collision |
| rx_end | input | 1 | One-cycle strobe when a received frame ends |
| rx_coll | input | 1 | Qualifies `rx_end`: the frame saw a collision |
| jam_limit | input | 8 | Consecutive-collision limit; zero disables leakage |
| jam_req | output | 1 | Registered one-cycle request to jam the arriving frame |
| leak_pulse | output | 1 | Registered one-cycle flag that the arriving frame is let through |

## Verification
The assertions assume that `rx_sof`, `tx_end` and `rx_end` are single-cycle strobes. They also assume that the collision flags matter only when their end strobe is high, and that `fill_level`, `fill_thresh` and `jam_limit` are stable on the cycle a start strobe is sampled. The stimulus drives every strobe for exactly one cycle, starting on a falling edge. It changes the levels and the limit only between strobes, and it often resets between scenarios so that each case starts from a known count of zero.

// File: rtl/bp_jam_pkg.sv
package bp_jam_pkg;
  localparam int unsigned LIMIT_W = 8;
  localparam int unsigned LEVEL_W = 8;

  typedef struct packed {
    logic tx_hit;
    logic rx_hit;
    logic clean;
  } coll_evt_t;
endpackage

// File: rtl/bp_fill_cmp.sv
module bp_fill_cmp #(
  parameter int unsigned LEVEL_W = 8
) (
  input  logic [LEVEL_W-1:0] level_i,
  input  logic [LEVEL_W-1:0] thresh_i,
  output logic               over_o
);
  assign over_o = (level_i >= thresh_i);
endmodule

// File: rtl/bp_coll_cnt.sv
module bp_coll_cnt
  import bp_jam_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  coll_evt_t        evt_i,
  input  logic             leak_clr_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W:0]   sum;
  logic [CNT_W-1:0] cnt_q;

  assign sum = {1'b0, cnt_q} + (CNT_W+1)'(evt_i.tx_hit) + (CNT_W+1)'(evt_i.rx_hit);

  always_ff @(posedge clk) begin
    if (rst)
      cnt_q <= '0;
    else if (leak_clr_i || evt_i.clean)
      cnt_q <= '0;
    else if (sum[CNT_W])
      cnt_q <= CNT_MAX;
    else
      cnt_q <= sum[CNT_W-1:0];
  end

  assign cnt_o = cnt_q;

  a_r4_clean_clears: assert property (@(posedge clk) disable iff (rst)
    evt_i.clean |=> (cnt_o == '0));
  a_r7_saturate: assert property (@(posedge clk) disable iff (rst)
    (cnt_o == CNT_MAX && !evt_i.clean && !leak_clr_i) |=> (cnt_o == CNT_MAX));
  a_r10_leak_clears: assert property (@(posedge clk) disable iff (rst)
    leak_clr_i |=> (cnt_o == '0));
  a_r3_single_step: assert property (@(posedge clk) disable iff (rst)
    (!evt_i.clean && !leak_clr_i && (evt_i.tx_hit ^ evt_i.rx_hit) && cnt_o != CNT_MAX)
      |=> (cnt_o == $past(cnt_o) + 1'b1));
endmodule

// File: rtl/bp_jam_decide.sv
module bp_jam_decide #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sof_i,
  input  logic             over_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             leak_now_o,
  output logic             jam_o,
  output logic             leak_o
);
  logic limit_hit;
  logic jam_now;
  logic jam_q, leak_q;

  assign limit_hit  = (limit_i != '0) && (cnt_i >= limit_i);
  assign leak_now_o = sof_i && over_i && limit_hit;
  assign jam_now    = sof_i && over_i && !limit_hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      jam_q  <= 1'b0;
      leak_q <= 1'b0;
    end else begin
      jam_q  <= jam_now;
      leak_q <= leak_now_o;
    end
  end

  assign jam_o  = jam_q;
  assign leak_o = leak_q;

  a_r1_jam_needs_over: assert property (@(posedge clk) disable iff (rst)
    jam_o |-> $past(over_i));
  a_r2_jam_follows_sof: assert property (@(posedge clk) disable iff (rst)
    jam_o |-> $past(sof_i));
  a_r2_jam_one_cycle: assert property (@(posedge clk) disable iff (rst)
    jam_o |=> !jam_o);
  a_r5_leak_at_limit: assert property (@(posedge clk) disable iff (rst)
    leak_o |-> $past(limit_i != '0 && cnt_i >= limit_i && over_i));
  a_r5_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(jam_o && leak_o));
  a_r6_zero_limit: assert property (@(posedge clk) disable iff (rst)
    (sof_i && over_i && limit_i == '0) |=> (jam_o && !leak_o));
endmodule

// File: rtl/bp_jam_ctrl.sv
module bp_jam_ctrl
  import bp_jam_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic [LEVEL_W-1:0] fill_level,
  input  logic [LEVEL_W-1:0] fill_thresh,
  input  logic               rx_sof,
  input  logic               tx_end,
  input  logic               tx_coll,
  input  logic               rx_end,
  input  logic               rx_coll,
  input  logic [LIMIT_W-1:0] jam_limit,
  output logic               jam_req,
  output logic               leak_pulse
);
  logic               over;
  logic               leak_now;
  logic [LIMIT_W-1:0] coll_cnt;
  coll_evt_t          evt;

  assign evt.tx_hit = tx_end && tx_coll;
  assign evt.rx_hit = rx_end && rx_coll;
  assign evt.clean  = (tx_end && !tx_coll) || (rx_end && !rx_coll);

  bp_fill_cmp #(.LEVEL_W(LEVEL_W)) cmp_i (
    .level_i  (fill_level),
    .thresh_i (fill_thresh),
    .over_o   (over)
  );

  bp_coll_cnt #(.CNT_W(LIMIT_W)) cnt_i (
    .clk        (clk),
    .rst        (rst),
    .evt_i      (evt),
    .leak_clr_i (leak_now),
    .cnt_o      (coll_cnt)
  );

  bp_jam_decide #(.CNT_W(LIMIT_W)) dec_i (
    .clk        (clk),
    .rst        (rst),
    .sof_i      (rx_sof),
    .over_i     (over),
    .cnt_i      (coll_cnt),
    .limit_i    (jam_limit),
    .leak_now_o (leak_now),
    .jam_o      (jam_req),
    .leak_o     (leak_pulse)
  );

  a_r8_below_keeps_count: assert property (@(posedge clk) disable iff (rst)
    (rx_sof && !over && !tx_end && !rx_end) |=> (coll_cnt == $past(coll_cnt) && !jam_req && !leak_pulse));
endmodule

// File: tb/bp_jam_ctrl_tb_top.sv
module bp_jam_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] fill_level = '0, fill_thresh = '0, jam_limit = '0;
  logic       rx_sof = 0, tx_end = 0, tx_coll = 0, rx_end = 0, rx_coll = 0;
  logic       jam_req, leak_pulse;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #4 clk = ~clk;

  bp_jam_ctrl dut_i (
    .clk(clk), .rst(rst), .fill_level(fill_level), .fill_thresh(fill_thresh),
    .rx_sof(rx_sof), .tx_end(tx_end), .tx_coll(tx_coll), .rx_end(rx_end),
    .rx_coll(rx_coll), .jam_limit(jam_limit), .jam_req(jam_req), .leak_pulse(leak_pulse)
  );

  // {ncoll[8:0], clean, limit[7:0], fill[7:0], thresh[7:0], exp_jam, exp_leak}
  localparam int NV = 10;
  localparam logic [35:0] VEC [NV] = '{
    {9'd0,   1'b0, 8'd3,   8'd100, 8'd50, 1'b1, 1'b0},
    {9'd0,   1'b0, 8'd3,   8'd10,  8'd50, 1'b0, 1'b0},
    {9'd0,   1'b0, 8'd3,   8'd50,  8'd50, 1'b1, 1'b0},
    {9'd3,   1'b0, 8'd3,   8'd100, 8'd50, 1'b0, 1'b1},
    {9'd2,   1'b0, 8'd3,   8'd100, 8'd50, 1'b1, 1'b0},
    {9'd3,   1'b1, 8'd3,   8'd100, 8'd50, 1'b1, 1'b0},
    {9'd5,   1'b0, 8'd0,   8'd100, 8'd50, 1'b1, 1'b0},
    {9'd300, 1'b0, 8'd255, 8'd100, 8'd50, 1'b0, 1'b1},
    {9'd4,   1'b0, 8'd3,   8'd10,  8'd50, 1'b0, 1'b0},
    {9'd1,   1'b0, 8'd1,   8'd100, 8'd50, 1'b0, 1'b1}
  };
  string vreq [NV] = '{"R1", "R1", "R1", "R5", "R3", "R4", "R6", "R7", "R8", "R3"};

  task automatic check(string req, logic [1:0] act, logic [1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: {jam,leak} actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk) rst = 1'b1;
    @(negedge clk) rst = 1'b0;
  endtask

  task automatic coll_end(bit use_tx);
    @(negedge clk);
    if (use_tx) begin tx_end = 1; tx_coll = 1; end
    else        begin rx_end = 1; rx_coll = 1; end
    @(negedge clk);
    tx_end = 0; tx_coll = 0; rx_end = 0; rx_coll = 0;
  endtask

  task automatic clean_end();
    @(negedge clk) rx_end = 1; rx_coll = 0;
    @(negedge clk) rx_end = 0;
  endtask

  // strobe start of frame, check the registered result and that it lasts one cycle
  task automatic sof_check(string req, logic [1:0] exp);
    @(negedge clk) rx_sof = 1;
    @(negedge clk) rx_sof = 0;
    check(req, {jam_req, leak_pulse}, exp);
    @(negedge clk);
    check("R2", {jam_req, leak_pulse}, 2'b00);
  endtask

  initial begin
    do_reset();
    // R9: reset state
    check("R9", {jam_req, leak_pulse}, 2'b00);

    for (int i = 0; i < NV; i++) begin
      do_reset();
      jam_limit   = VEC[i][25:18];
      fill_level  = VEC[i][17:10];
      fill_thresh = VEC[i][9:2];
      for (int k = 0; k < int'(VEC[i][35:27]); k++) coll_end(k % 2 == 0);
      if (VEC[i][26]) clean_end();
      sof_check(vreq[i], VEC[i][1:0]);
    end

    // R2: no start strobe, no jam even when over threshold
    do_reset();
    fill_level = 8'd200; fill_thresh = 8'd10; jam_limit = 8'd2;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      check("R2", {jam_req, leak_pulse}, 2'b00);
    end

    // R5: after a leak the count restarts, so the next frame is jammed
    for (int k = 0; k < 2; k++) coll_end(1'b0);
    sof_check("R5", 2'b01);
    sof_check("R5", 2'b10);

    // R3: two collided ends in one cycle count as two
    do_reset();
    @(negedge clk) begin tx_end = 1; tx_coll = 1; rx_end = 1; rx_coll = 1; end
    @(negedge clk) begin tx_end = 0; tx_coll = 0; rx_end = 0; rx_coll = 0; end
    sof_check("R3", 2'b01);

    // R4: clean end beats a collided end in the same cycle
    do_reset();
    jam_limit = 8'd1;
    @(negedge clk) begin tx_end = 1; tx_coll = 1; rx_end = 1; rx_coll = 0; end
    @(negedge clk) begin tx_end = 0; tx_coll = 0; rx_end = 0; end
    sof_check("R4", 2'b10);

    // R8: below-threshold start keeps the count, later over-threshold start leaks
    do_reset();
    jam_limit = 8'd2; fill_level = 8'd5;
    for (int k = 0; k < 2; k++) coll_end(1'b1);
    sof_check("R8", 2'b00);
    fill_level = 8'd200;
    sof_check("R8", 2'b01);

    // R10: leak in the same cycle as a collided end drops that increment
    do_reset();
    jam_limit = 8'd1;
    coll_end(1'b1);
    @(negedge clk) begin rx_sof = 1; tx_end = 1; tx_coll = 1; end
    @(negedge clk) begin rx_sof = 0; tx_end = 0; tx_coll = 0; end
    check("R10", {jam_req, leak_pulse}, 2'b01);
    sof_check("R10", 2'b10);

    // R9: reset clears a non-zero count
    coll_end(1'b0);
    do_reset();
    check("R9", {jam_req, leak_pulse}, 2'b00);
    sof_check("R9", 2'b10);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule